// File: doc/BRIEF.md
# Reset Cause Unit

This block collects reset requests from every reset source of a small microcontroller and turns them into one synchronous, active-low system reset. The sources are a power-on detector, a low-voltage detector, an external active-low reset pin, a watchdog timeout, an illegal opcode, an illegal address, a clock-generator fault and a reset forced by a debug host. Any active request pulls the system reset low. The reset then stays low for a fixed number of clocks after the last request goes away.

While the reset is held, each source that asks for it is remembered in a sticky latch. When the reset is released, the remembered sources are copied into a read-only 8-bit status register. That register keeps its value until the next reset. Software reads it through a single select strobe. A bus write to the same select gives a one-cycle watchdog-clear strobe and leaves the register as it was.

The block also qualifies some requests before they count. A STOP or a background instruction only counts as an illegal opcode when its enable input is low. A watchdog timeout only counts when the watchdog enable is high. The status register has its own asynchronous clear, so its contents survive every reset that is not a power-on clear.

Top module: `rstcause_unit`

## Requirements
- R1: Status layout: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 clock-generator fault, bit 1 low-voltage. Bit 0 always reads 0.
- R2: On every reset, each flag whose source was requested while the reset was pending is set. Every other flag is cleared.
- R3: A power-on request sets the low-voltage flag as well as the power-on flag, so a power-on reset alone reads 0x82.
- R4: A debug-forced request (`dbg_force` = 1) causes a full reset but sets no status flag. On its own it leaves the status at 0x00.
- R5: When `bus_sel` = 1 and `bus_wr` = 1, `wdog_clear` is 1 in that same cycle and the status register keeps its value.
- R6: `wdog_timeout` causes a reset and sets bit 5 only when `wdog_en` = 1. With `wdog_en` = 0 it has no effect.
- R7: `stop_exec` with `stop_en` = 0 is an illegal-opcode reset and sets bit 4. `bgnd_exec` with `bdm_en` = 0 is treated the same way. With the matching enable at 1, neither input has any effect.
- R8: A low level on `rst_pin_n` is a reset request after a synchronizer of `SYNC_STAGES` flops. With the default of 2, the reset asserts two clocks later than a direct source would.
- R9: `sys_rst_n` goes low the clock after any request. It rises `RST_CYCLES` clocks (default 8) after the last clock in which a request was sampled. The status changes only on that rising edge.
- R10: `por_clr_n` = 0 clears the status to 0x00 asynchronously and holds `sys_rst_n` low. After `por_clr_n` rises, `sys_rst_n` stays low for `RST_CYCLES` more clocks.
- R11: `rdata` shows the status register while `bus_sel` = 1 and reads 0x00 while `bus_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_clr_n | input | 1 | Power-on clear, active low; asynchronous for the status register, synchronous for the rest of the block |
| por_det | input | 1 | Power-on detector request |
| lvd_det | input | 1 | Low-voltage detector request |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_timeout | input | 1 | Watchdog timeout request |
| wdog_en | input | 1 | Watchdog reset enable |
| illegal_op | input | 1 | Illegal opcode request from the core |
| stop_exec | input | 1 | STOP instruction executed |
| stop_en | input | 1 | STOP allowed; when 0, STOP is illegal |
| bgnd_exec | input | 1 | Background instruction executed |
| bdm_en | input | 1 | Background debug allowed; when 0, the background instruction is illegal |
| illegal_addr | input | 1 | Illegal address request |
| clk_fault | input | 1 | Clock-generator fault request |
| dbg_force | input | 1 | Debug host forced reset |
| bus_sel | input | 1 | Status address selected |
| bus_wr | input | 1 | Bus write qualifier |
| rdata | output | 8 | Read data (status register when selected) |
| wdog_clear | output | 1 | Watchdog clear strobe |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The hardest case to reach from the ports is a pin request arriving partway through a reset that another source has already started. The synchronizer delays the pin request, so it lands after the stretch counter is running. The counter must then reload, and the sticky latches must merge both sources before the release. The bench sweeps every combination of the seven flagged sources, with the watchdog enable at both values, all applied in the same clock. Each time, it checks the captured status and the exact low length of `sys_rst_n`. That length is 8, or 10 when the pin joins another source. Directed runs cover the STOP and background qualifiers, debug-forced resets, the write strobe and the asynchronous clear.

// File: rtl/rcu_pkg.sv
`timescale 1ns/1ps
// Package: shared flag positions and status type for the reset cause unit.
// Assumes an 8-bit status register; bit positions are decoded by software.
package rcu_pkg;
    localparam int FLAG_W   = 8;
    localparam int BIT_POR  = 7;
    localparam int BIT_PIN  = 6;
    localparam int BIT_WDG  = 5;
    localparam int BIT_ILOP = 4;
    localparam int BIT_ILAD = 3;
    localparam int BIT_CLKF = 2;
    localparam int BIT_LVD  = 1;
    typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/rcu_pin_sync.sv
`timescale 1ns/1ps
// rcu_pin_sync: synchronizes the asynchronous active-low reset pin and
// presents it as an active-high request. Assumes STAGES >= 2.
module rcu_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    input  logic pin_n,
    output logic req
);
    logic [STAGES-1:0] sh_q;

    // Shift the pin level through the synchronizer chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!clr_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], pin_n};
    end

    assign req = ~sh_q[STAGES-1];
endmodule

// File: rtl/rcu_src_decode.sv
`timescale 1ns/1ps
// rcu_src_decode: qualifies raw reset sources into per-flag requests and a
// combined request. Assumes all inputs are synchronous to clk.
module rcu_src_decode
    import rcu_pkg::*;
(
    input  logic   por_det,
    input  logic   lvd_det,
    input  logic   pin_req,
    input  logic   wdog_timeout,
    input  logic   wdog_en,
    input  logic   illegal_op,
    input  logic   stop_exec,
    input  logic   stop_en,
    input  logic   bgnd_exec,
    input  logic   bdm_en,
    input  logic   illegal_addr,
    input  logic   clk_fault,
    input  logic   dbg_force,
    output flags_t req_flags,
    output logic   any_req
);
    logic ilop_q;

    // Illegal opcode: direct request or a disabled STOP / background instruction.
    always_comb begin
        ilop_q = illegal_op | (stop_exec & ~stop_en) | (bgnd_exec & ~bdm_en);
    end

    // Map each qualified source onto its status bit; power-on also marks low voltage.
    always_comb begin
        req_flags           = '0;
        req_flags[BIT_POR]  = por_det;
        req_flags[BIT_PIN]  = pin_req;
        req_flags[BIT_WDG]  = wdog_timeout & wdog_en;
        req_flags[BIT_ILOP] = ilop_q;
        req_flags[BIT_ILAD] = illegal_addr;
        req_flags[BIT_CLKF] = clk_fault;
        req_flags[BIT_LVD]  = lvd_det | por_det;
    end

    // Debug-forced reset requests a reset without contributing a flag.
    always_comb begin
        any_req = (|req_flags) | dbg_force;
    end
endmodule

// File: rtl/rcu_seq.sv
`timescale 1ns/1ps
// rcu_seq: stretches requests into a reset of RST_CYCLES clocks after the
// last request and accumulates requested flags in sticky latches.
// Assumes RST_CYCLES >= 2. Synchronous active-low clear.
module rcu_seq
    import rcu_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic   clk,
    input  logic   clr_n,
    input  logic   any_req,
    input  flags_t req_flags,
    output logic   rst_active,
    output logic   release_p,
    output flags_t captured
);
    localparam int CNT_W = $clog2(RST_CYCLES);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    flags_t           sticky_q;

    // Release happens on the last counted cycle with no new request.
    always_comb begin
        release_p = active_q && (cnt_q == '0) && !any_req;
    end

    // Reset stretch counter: reload on every request, count down otherwise.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            active_q <= 1'b1;
            cnt_q    <= LOAD;
        end else if (any_req) begin
            active_q <= 1'b1;
            cnt_q    <= LOAD;
        end else if (active_q) begin
            if (cnt_q == '0) active_q <= 1'b0;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    // Sticky request latches, emptied when their content is handed over.
    always_ff @(posedge clk) begin
        if (!clr_n)         sticky_q <= '0;
        else if (release_p) sticky_q <= '0;
        else                sticky_q <= sticky_q | req_flags;
    end

    assign rst_active = active_q;
    assign captured   = sticky_q;
endmodule

// File: rtl/rcu_status.sv
`timescale 1ns/1ps
// rcu_status: read-only reset status register with its own asynchronous
// power-on clear; loaded only on reset release.
module rcu_status
    import rcu_pkg::*;
(
    input  logic   clk,
    input  logic   clr_n,
    input  logic   load,
    input  flags_t load_val,
    input  logic   sel,
    output flags_t status,
    output flags_t rdata
);
    flags_t status_q;

    // Capture the accumulated flags on release; bit 0 is always forced to 0.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)    status_q <= '0;
        else if (load) status_q <= {load_val[FLAG_W-1:1], 1'b0};
    end

    // Drive read data only while the status address is selected.
    always_comb begin
        rdata = sel ? status_q : '0;
    end

    assign status = status_q;
endmodule

// File: rtl/rstcause_unit.sv
`timescale 1ns/1ps
// rstcause_unit: top of the reset cause unit. Combines reset sources into
// one active-low system reset, records the causes and serves status reads.
// Assumes bus strobes are synchronous to clk.
module rstcause_unit
    import rcu_pkg::*;
#(
    parameter int RST_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_clr_n,
    input  logic       por_det,
    input  logic       lvd_det,
    input  logic       rst_pin_n,
    input  logic       wdog_timeout,
    input  logic       wdog_en,
    input  logic       illegal_op,
    input  logic       stop_exec,
    input  logic       stop_en,
    input  logic       bgnd_exec,
    input  logic       bdm_en,
    input  logic       illegal_addr,
    input  logic       clk_fault,
    input  logic       dbg_force,
    input  logic       bus_sel,
    input  logic       bus_wr,
    output logic [7:0] rdata,
    output logic       wdog_clear,
    output logic       sys_rst_n
);
    logic   pin_req;
    logic   any_req;
    logic   rst_active;
    logic   release_p;
    flags_t req_flags;
    flags_t captured;
    flags_t status_q;

    rcu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .clr_n (por_clr_n),
        .pin_n (rst_pin_n),
        .req   (pin_req)
    );

    rcu_src_decode u_dec (
        .por_det      (por_det),
        .lvd_det      (lvd_det),
        .pin_req      (pin_req),
        .wdog_timeout (wdog_timeout),
        .wdog_en      (wdog_en),
        .illegal_op   (illegal_op),
        .stop_exec    (stop_exec),
        .stop_en      (stop_en),
        .bgnd_exec    (bgnd_exec),
        .bdm_en       (bdm_en),
        .illegal_addr (illegal_addr),
        .clk_fault    (clk_fault),
        .dbg_force    (dbg_force),
        .req_flags    (req_flags),
        .any_req      (any_req)
    );

    rcu_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk        (clk),
        .clr_n      (por_clr_n),
        .any_req    (any_req),
        .req_flags  (req_flags),
        .rst_active (rst_active),
        .release_p  (release_p),
        .captured   (captured)
    );

    rcu_status u_stat (
        .clk      (clk),
        .clr_n    (por_clr_n),
        .load     (release_p),
        .load_val (captured),
        .sel      (bus_sel),
        .status   (status_q),
        .rdata    (rdata)
    );

    // Any write to the status address clears the watchdog, never the register.
    always_comb begin
        wdog_clear = bus_sel & bus_wr;
    end

    assign sys_rst_n = ~rst_active;
endmodule

// File: rtl/rcu_checker.sv
`timescale 1ns/1ps
// rcu_checker: property checks for rstcause_unit, attached by bind.
module rcu_checker #(
    parameter int RST_CYCLES = 8
) (
    input logic       clk,
    input logic       por_clr_n,
    input logic       sys_rst_n,
    input logic       any_req,
    input logic [7:0] status_q,
    input logic [7:0] rdata,
    input logic       bus_sel,
    input logic       bus_wr
);
    localparam int LW = $clog2(RST_CYCLES) + 2;
    logic [LW-1:0] low_cnt;

    // Count consecutive cycles with the system reset low (saturating).
    always_ff @(posedge clk) begin
        if (!por_clr_n)          low_cnt <= '0;
        else if (sys_rst_n)      low_cnt <= '0;
        else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
    end

    AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!por_clr_n) rdata[0] == 1'b0); // R1
    AST_POR_MARKS_LVD: assert property (@(posedge clk) disable iff (!por_clr_n) status_q[7] |-> status_q[1]); // R3
    AST_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!por_clr_n) (bus_sel && bus_wr && sys_rst_n && !any_req) |=> $stable(status_q)); // R5
    AST_REQ_ASSERTS_RESET: assert property (@(posedge clk) disable iff (!por_clr_n) any_req |=> !sys_rst_n); // R9
    AST_STATUS_ON_RELEASE: assert property (@(posedge clk) disable iff (!por_clr_n) !$stable(status_q) |-> $rose(sys_rst_n)); // R9
    AST_MIN_RESET_WIDTH: assert property (@(posedge clk) disable iff (!por_clr_n) $rose(sys_rst_n) |-> (int'(low_cnt) >= RST_CYCLES)); // R10
endmodule

bind rstcause_unit rcu_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .por_clr_n (por_clr_n),
    .sys_rst_n (sys_rst_n),
    .any_req   (any_req),
    .status_q  (status_q),
    .rdata     (rdata),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr)
);

// File: tb/sim_rstcause_unit.sv
`timescale 1ns/1ps
// sim_rstcause_unit: sweeps all source combinations and directed corners.
module sim_rstcause_unit;
    logic clk = 1'b0;
    logic por_clr_n, por_det, lvd_det, rst_pin_n, wdog_timeout, wdog_en;
    logic illegal_op, stop_exec, stop_en, bgnd_exec, bdm_en;
    logic illegal_addr, clk_fault, dbg_force, bus_sel, bus_wr;
    logic [7:0] rdata;
    logic wdog_clear, sys_rst_n;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] prev_status;

    always #4 clk = ~clk;

    rstcause_unit u0 (
        .clk(clk), .por_clr_n(por_clr_n), .por_det(por_det), .lvd_det(lvd_det),
        .rst_pin_n(rst_pin_n), .wdog_timeout(wdog_timeout), .wdog_en(wdog_en),
        .illegal_op(illegal_op), .stop_exec(stop_exec), .stop_en(stop_en),
        .bgnd_exec(bgnd_exec), .bdm_en(bdm_en), .illegal_addr(illegal_addr),
        .clk_fault(clk_fault), .dbg_force(dbg_force), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .rdata(rdata), .wdog_clear(wdog_clear), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_sources();
        por_det = 0; lvd_det = 0; rst_pin_n = 1; wdog_timeout = 0;
        illegal_op = 0; stop_exec = 0; bgnd_exec = 0; illegal_addr = 0;
        clk_fault = 0; dbg_force = 0;
    endtask

    // Called at a negedge with sources set; holds them one cycle, then measures.
    task automatic fire(output int low_len, output bit saw);
        low_len = 0; saw = 0;
        @(negedge clk);
        clear_sources();
        for (int i = 0; i < 40; i++) begin
            if (!sys_rst_n) begin low_len++; saw = 1; end
            else if (saw) break;
            @(negedge clk);
        end
    endtask

    task automatic read_status(output logic [7:0] v);
        bus_sel = 1; #1; v = rdata; bus_sel = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int len;
        bit saw;
        logic [7:0] v;
        clear_sources();
        por_clr_n = 0; wdog_en = 0; stop_en = 1; bdm_en = 1; bus_sel = 0; bus_wr = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(sys_rst_n == 0, "R10 reset held during clear", sys_rst_n, 0);
        read_status(v);
        check(v == 8'h00, "R10 status cleared", v, 0);
        por_clr_n = 1;
        len = 0;
        for (int i = 0; i < 30 && !sys_rst_n; i++) begin @(negedge clk); len++; end
        check(len == 8, "R10 reset length after clear", len, 8);
        prev_status = 8'h00;

        // R1 R2 R3 R6 R8 R9: sweep of all seven flagged sources x watchdog enable
        for (int c = 0; c < 256; c++) begin
            logic [7:0] ef;
            logic [7:0] others;
            int el;
            wdog_en = c[7];
            por_det = c[6]; rst_pin_n = ~c[5]; wdog_timeout = c[4];
            illegal_op = c[3]; illegal_addr = c[2]; clk_fault = c[1]; lvd_det = c[0];
            ef = {c[6], c[5], c[4] & c[7], c[3], c[2], c[1], c[0] | c[6], 1'b0};
            others = ef & 8'hBF;
            el = (c[5] && others != 0) ? 10 : 8;
            fire(len, saw);
            check(saw == (ef != 0), "R6 reset occurs only for enabled source", saw, ef != 0);
            if (ef != 0) begin
                check(len == el, "R9 R8 reset length", len, el);
                prev_status = ef;
            end
            read_status(v);
            check(v == prev_status, "R2 R3 status flags", v, prev_status);
        end

        // R7: STOP and background qualifiers
        stop_en = 0; stop_exec = 1; fire(len, saw); read_status(v);
        check(saw && v == 8'h10, "R7 stop illegal when disabled", v, 8'h10);
        lvd_det = 1; fire(len, saw); read_status(v);
        stop_en = 1; stop_exec = 1; fire(len, saw); read_status(v);
        check(!saw && v == 8'h02, "R7 stop ignored when enabled", v, 8'h02);
        bdm_en = 0; bgnd_exec = 1; fire(len, saw); read_status(v);
        check(saw && v == 8'h10, "R7 background illegal when disabled", v, 8'h10);
        bdm_en = 1; bgnd_exec = 1; fire(len, saw); read_status(v);
        check(!saw && v == 8'h10, "R7 background ignored when enabled", v, 8'h10);

        // R4: debug-forced reset
        dbg_force = 1; fire(len, saw); read_status(v);
        check(saw && len == 8, "R4 debug reset length", len, 8);
        check(v == 8'h00, "R4 debug sets no flag", v, 0);
        dbg_force = 1; por_det = 1; fire(len, saw); read_status(v);
        check(v == 8'h82, "R4 R3 debug with power-on", v, 8'h82);

        // R5: write clears watchdog, status unchanged
        bus_sel = 1; bus_wr = 1; #1;
        check(wdog_clear == 1, "R5 watchdog clear strobe", wdog_clear, 1);
        @(negedge clk); @(negedge clk);
        check(rdata == 8'h82, "R5 status unchanged by write", rdata, 8'h82);
        bus_wr = 0; #1;
        check(wdog_clear == 0, "R5 no strobe on read", wdog_clear, 0);
        bus_sel = 0; #1;
        // R11: deselected reads zero
        check(rdata == 8'h00, "R11 deselected read", rdata, 0);
        check(sys_rst_n == 1, "R5 write causes no reset", sys_rst_n, 1);

        // R10: asynchronous clear between edges
        #1; por_clr_n = 0; bus_sel = 1; #1;
        check(rdata == 8'h00, "R10 async clear of status", rdata, 0);
        bus_sel = 0;
        @(negedge clk);
        check(sys_rst_n == 0, "R10 reset during clear", sys_rst_n, 0);
        por_clr_n = 1;
        repeat (12) @(negedge clk);
        check(sys_rst_n == 1, "R10 released after clear", sys_rst_n, 1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule